// File: doc/BRIEF.md
# Serial Port Clock Polarity Front-End

This block is the bit-clock and data-edge stage of a synchronous serial port, and it runs entirely on a fast system clock. The transmit and receive directions each have their own bit-clock path. A path either makes its own bit clock with a programmable divider and drives it onto the clock pin, or it takes the bit clock in from that pin through a two-flop synchronizer. A polarity bit per direction inverts the clock where it crosses the pin. When the clock is generated inside, the inversion is applied on the way out. When the clock comes from outside, it is applied on the way in.

Inside the block the active edges are fixed. The transmitter launches a bit on each rising edge of its internal bit clock. The receiver samples on each falling edge of its internal bit clock. Each of these edges becomes a one-system-cycle strobe. The transmit strobe shifts an 8-bit word out, most significant bit first. The receive strobe shifts the data pin into an 8-bit register, which reports a complete word with a one-cycle valid pulse.

When one clock serves both directions and the two polarity bits are equal, the receiver samples half a bit after the transmitter launches. Each direction has an enable. While the enable is low, that direction is held idle and takes in its configuration.

Top module: `spclk_frontend`

## Requirements
- R1: In internal clock mode, the clock output enable is 1. The clock pin output is a square wave whose halves each last max(half,1) system cycles. During the first half after the enable rises, the pin is at the polarity-bit level, which is the low phase of the uninverted clock.
- R2: One cycle after any clock edge at which a direction's enable is low, that direction's clock pin output equals the value its polarity input had at that edge.
- R3: In external clock mode, the clock output enable is 0. The clock pin input passes through a two-flop synchronizer and is inverted when the polarity bit is 1.
- R4: A word written with tx_load goes out on tx_data_out most significant bit first. One bit is launched per rising edge of the internal transmit clock. In external mode that edge is a rising pin edge when polarity is 0 and a falling pin edge when polarity is 1.
- R5: rx_data_in is sampled on each falling edge of the internal receive clock. In external mode that edge is a falling pin edge when polarity is 0 and a rising pin edge when polarity is 1.
- R6: After every eighth sample, rx_word holds the last eight samples, with the first-sampled bit in bit 7. rx_valid is 1 for exactly one system cycle.
- R7: Polarity, clock mode and half-period inputs are captured only at clock edges where the direction's enable is low. Changes to them while the direction is enabled have no effect on the clock pin, the output enable or the data.
- R8: A low enable suppresses that direction's strobes, holds tx_data_out at 0 and clears the receive bit count. After a partial word, the next word is framed from its first bit.
- R9: With data looped back and one bit clock serving both directions (internal transmit clock fed to the receive pin, a common external clock, or two internal dividers of equal ratio started together), equal polarity bits yield received words equal to the sent words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit direction enable; low holds it idle and captures its configuration |
| tx_pol | input | 1 | Transmit clock polarity bit |
| tx_int | input | 1 | Transmit clock mode, 1 = internal divider, 0 = external pin |
| tx_half | input | DIV_W | Transmit divider half period in system cycles (0 acts as 1) |
| tx_clk_in | input | 1 | Transmit clock pin, input side |
| tx_clk_out | output | 1 | Transmit clock pin, output side |
| tx_clk_oe | output | 1 | Transmit clock pin output enable |
| tx_load | input | 1 | Writes tx_word into the transmit shift register |
| tx_word | input | W | Word to transmit |
| tx_data_out | output | 1 | Serial data output |
| rx_en | input | 1 | Receive direction enable; low holds it idle and captures its configuration |
| rx_pol | input | 1 | Receive clock polarity bit |
| rx_int | input | 1 | Receive clock mode, 1 = internal divider, 0 = external pin |
| rx_half | input | DIV_W | Receive divider half period in system cycles (0 acts as 1) |
| rx_clk_in | input | 1 | Receive clock pin, input side |
| rx_clk_out | output | 1 | Receive clock pin, output side |
| rx_clk_oe | output | 1 | Receive clock pin output enable |
| rx_data_in | input | 1 | Serial data input |
| rx_word | output | W | Last complete received word |
| rx_valid | output | 1 | One-cycle pulse when rx_word is updated |

## Verification
The bench checks the edge pairing in all four polarity and mode combinations per direction. A design that sampled on the wrong edge, or inverted on the wrong side of the pin, would catch each bit at the moment it changes. The received word would then come back shifted by a bit instead of equal to the sent word.

Several corner cases get their own tests:
- A half period of 0 is used to check the one-cycle clamp. A wrong clamp would stall or mistime the clock pin, and the per-cycle pin model flags it.
- Configuration inputs are flipped in the middle of a word. A design that took them in while enabled would change the pin or the output enable at once.
- A word is abandoned after three bits. A design that kept the partial bit count would mis-frame the next word.

// File: rtl/spclk_pkg.sv
package spclk_pkg;

    typedef enum logic {
        CLK_EXTERNAL = 1'b0,
        CLK_INTERNAL = 1'b1
    } clk_src_e;

    typedef struct packed {
        logic     pol;
        clk_src_e src;
    } clk_cfg_t;

    // Bit clock seen by the shifters: fixed active edges inside the block.
    function automatic logic inner_clock(clk_cfg_t c, logic div_q, logic pin_s);
        return (c.src == CLK_INTERNAL) ? div_q : (pin_s ^ c.pol);
    endfunction

    // Level driven toward the clock pin.
    function automatic logic pin_level(clk_cfg_t c, logic div_q);
        return div_q ^ c.pol;
    endfunction

endpackage

// File: rtl/spclk_sync2.sv
module spclk_sync2 #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/spclk_divider.sv
module spclk_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] limit,
    output logic             q
);
    logic [DIV_W-1:0] cnt_q;
    logic             q_r;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
            q_r   <= 1'b0;
        end else if (cnt_q >= limit) begin
            cnt_q <= '0;
            q_r   <= ~q_r;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign q = q_r;
endmodule

// File: rtl/spclk_clkpath.sv
module spclk_clkpath
    import spclk_pkg::*;
#(
    parameter int DIV_W          = 8,
    parameter int SYNC_N         = 2,
    parameter bit STROBE_ON_RISE = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  clk_cfg_t         cfg_in,
    input  logic [DIV_W-1:0] half_in,
    input  logic             pin_in,
    output logic             pin_out,
    output logic             pin_oe,
    output logic             stb
);
    clk_cfg_t         cfg_q;
    logic [DIV_W-1:0] limit_q;
    logic             pin_s;
    logic             div_q;
    logic             bclk;
    logic             prev_q;

    // Configuration is only taken while the direction is idle.
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '{pol: 1'b0, src: CLK_EXTERNAL};
            limit_q <= '0;
        end else if (!en) begin
            cfg_q   <= cfg_in;
            limit_q <= (half_in == '0) ? '0 : half_in - 1'b1;
        end
    end

    spclk_sync2 #(.STAGES(SYNC_N)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pin_s)
    );

    spclk_divider #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst   (rst),
        .run   (en),
        .limit (limit_q),
        .q     (div_q)
    );

    assign bclk = inner_clock(cfg_q, div_q, pin_s);

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= bclk;
    end

    generate
        if (STROBE_ON_RISE) begin : g_rise
            assign stb = en & bclk & ~prev_q;
        end else begin : g_fall
            assign stb = en & ~bclk & prev_q;
        end
    endgenerate

    assign pin_out = pin_level(cfg_q, div_q);
    assign pin_oe  = (cfg_q.src == CLK_INTERNAL);
endmodule

// File: rtl/spclk_txshift.sv
module spclk_txshift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         load,
    input  logic [W-1:0] word,
    input  logic         shift,
    output logic         dout
);
    logic [W-1:0] sr_q;
    logic         dout_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q   <= '0;
            dout_q <= 1'b0;
        end else begin
            if (!en) dout_q <= 1'b0;
            if (load) begin
                sr_q <= word;
            end else if (en && shift) begin
                dout_q <= sr_q[W-1];
                sr_q   <= {sr_q[W-2:0], 1'b0};
            end
        end
    end

    assign dout = dout_q;
endmodule

// File: rtl/spclk_rxshift.sv
module spclk_rxshift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         sample,
    input  logic         din,
    output logic [W-1:0] word,
    output logic         valid
);
    localparam int CNT_W = $clog2(W);

    logic [W-1:0]     sr_q;
    logic [W-1:0]     sr_nx;
    logic [W-1:0]     word_q;
    logic [CNT_W-1:0] cnt_q;
    logic             valid_q;

    always_comb sr_nx = {sr_q[W-2:0], din};

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q    <= '0;
            word_q  <= '0;
            cnt_q   <= '0;
            valid_q <= 1'b0;
        end else if (!en) begin
            cnt_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (sample) begin
                sr_q <= sr_nx;
                if (cnt_q == CNT_W'(W - 1)) begin
                    cnt_q   <= '0;
                    word_q  <= sr_nx;
                    valid_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign word  = word_q;
    assign valid = valid_q;
endmodule

// File: rtl/spclk_frontend.sv
module spclk_frontend
    import spclk_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int W      = 8,
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_en,
    input  logic             tx_pol,
    input  logic             tx_int,
    input  logic [DIV_W-1:0] tx_half,
    input  logic             tx_clk_in,
    output logic             tx_clk_out,
    output logic             tx_clk_oe,
    input  logic             tx_load,
    input  logic [W-1:0]     tx_word,
    output logic             tx_data_out,
    input  logic             rx_en,
    input  logic             rx_pol,
    input  logic             rx_int,
    input  logic [DIV_W-1:0] rx_half,
    input  logic             rx_clk_in,
    output logic             rx_clk_out,
    output logic             rx_clk_oe,
    input  logic             rx_data_in,
    output logic [W-1:0]     rx_word,
    output logic             rx_valid
);
    localparam int N_DIR = 2;
    localparam int TX    = 0;
    localparam int RX    = 1;

    logic             en_a      [N_DIR];
    clk_cfg_t         cfg_a     [N_DIR];
    logic [DIV_W-1:0] half_a    [N_DIR];
    logic             pin_in_a  [N_DIR];
    logic             pin_out_a [N_DIR];
    logic             oe_a      [N_DIR];
    logic             stb_a     [N_DIR];

    assign en_a[TX]     = tx_en;
    assign en_a[RX]     = rx_en;
    assign cfg_a[TX]    = '{pol: tx_pol, src: clk_src_e'(tx_int)};
    assign cfg_a[RX]    = '{pol: rx_pol, src: clk_src_e'(rx_int)};
    assign half_a[TX]   = tx_half;
    assign half_a[RX]   = rx_half;
    assign pin_in_a[TX] = tx_clk_in;
    assign pin_in_a[RX] = rx_clk_in;

    // Transmit path strobes on rising inner edges, receive path on falling.
    generate
        for (genvar d = 0; d < N_DIR; d++) begin : g_path
            spclk_clkpath #(
                .DIV_W          (DIV_W),
                .SYNC_N         (SYNC_N),
                .STROBE_ON_RISE (d == TX)
            ) u_path (
                .clk     (clk),
                .rst     (rst),
                .en      (en_a[d]),
                .cfg_in  (cfg_a[d]),
                .half_in (half_a[d]),
                .pin_in  (pin_in_a[d]),
                .pin_out (pin_out_a[d]),
                .pin_oe  (oe_a[d]),
                .stb     (stb_a[d])
            );
        end
    endgenerate

    assign tx_clk_out = pin_out_a[TX];
    assign tx_clk_oe  = oe_a[TX];
    assign rx_clk_out = pin_out_a[RX];
    assign rx_clk_oe  = oe_a[RX];

    spclk_txshift #(.W(W)) u_tx (
        .clk   (clk),
        .rst   (rst),
        .en    (tx_en),
        .load  (tx_load),
        .word  (tx_word),
        .shift (stb_a[TX]),
        .dout  (tx_data_out)
    );

    spclk_rxshift #(.W(W)) u_rx (
        .clk    (clk),
        .rst    (rst),
        .en     (rx_en),
        .sample (stb_a[RX]),
        .din    (rx_data_in),
        .word   (rx_word),
        .valid  (rx_valid)
    );
endmodule

// File: rtl/spclk_frontend_chk.sv
module spclk_frontend_chk (
    input logic clk,
    input logic rst,
    input logic tx_en,
    input logic tx_pol,
    input logic tx_clk_out,
    input logic tx_clk_oe,
    input logic tx_data_out,
    input logic rx_en,
    input logic rx_pol,
    input logic rx_clk_out,
    input logic rx_clk_oe,
    input logic rx_valid
);
    assert_idle_pin_tx_R2: assert property (@(posedge clk) disable iff (rst)
        !tx_en |=> (tx_clk_out == $past(tx_pol)));

    assert_idle_pin_rx_R2: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> (rx_clk_out == $past(rx_pol)));

    assert_oe_frozen_tx_R7: assert property (@(posedge clk) disable iff (rst)
        (tx_en && $past(tx_en)) |-> $stable(tx_clk_oe));

    assert_oe_frozen_rx_R7: assert property (@(posedge clk) disable iff (rst)
        (rx_en && $past(rx_en)) |-> $stable(rx_clk_oe));

    assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    assert_no_word_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> !rx_valid);

    assert_tx_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !tx_en |=> !tx_data_out);
endmodule

bind spclk_frontend spclk_frontend_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .tx_en       (tx_en),
    .tx_pol      (tx_pol),
    .tx_clk_out  (tx_clk_out),
    .tx_clk_oe   (tx_clk_oe),
    .tx_data_out (tx_data_out),
    .rx_en       (rx_en),
    .rx_pol      (rx_pol),
    .rx_clk_out  (rx_clk_out),
    .rx_clk_oe   (rx_clk_oe),
    .rx_valid    (rx_valid)
);

// File: tb/tb_spclk_frontend.sv
module tb_spclk_frontend;
    localparam int DIV_W    = 8;
    localparam int W        = 8;
    localparam int EXT_HALF = 6;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic             rst = 1'b1;
    logic             tx_en = 1'b0, tx_pol = 1'b0, tx_int = 1'b0, tx_load = 1'b0;
    logic [DIV_W-1:0] tx_half = '0, rx_half = '0;
    logic [W-1:0]     tx_word = '0;
    logic             rx_en = 1'b0, rx_pol = 1'b0, rx_int = 1'b0;
    logic             tx_clk_in, rx_clk_in, rx_data_in;
    logic             tx_clk_out, tx_clk_oe, tx_data_out;
    logic             rx_clk_out, rx_clk_oe, rx_valid;
    logic [W-1:0]     rx_word;

    logic ext_clk = 1'b0, ext_idle = 1'b0, ext_run = 1'b0, rx_from_tx = 1'b0;
    int   ext_cnt = 0;

    assign tx_clk_in  = ext_clk;
    assign rx_clk_in  = rx_from_tx ? tx_clk_out : ext_clk;
    assign rx_data_in = tx_data_out;

    spclk_frontend #(.DIV_W(DIV_W), .W(W)) dut (
        .clk(clk), .rst(rst),
        .tx_en(tx_en), .tx_pol(tx_pol), .tx_int(tx_int), .tx_half(tx_half),
        .tx_clk_in(tx_clk_in), .tx_clk_out(tx_clk_out), .tx_clk_oe(tx_clk_oe),
        .tx_load(tx_load), .tx_word(tx_word), .tx_data_out(tx_data_out),
        .rx_en(rx_en), .rx_pol(rx_pol), .rx_int(rx_int), .rx_half(rx_half),
        .rx_clk_in(rx_clk_in), .rx_clk_out(rx_clk_out), .rx_clk_oe(rx_clk_oe),
        .rx_data_in(rx_data_in), .rx_word(rx_word), .rx_valid(rx_valid)
    );

    int checks = 0, fails = 0, cyc = 0;
    bit mon_on = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // External bench clock shared by the pins in external-mode runs.
    always @(negedge clk) begin
        if (!ext_run) begin
            ext_clk <= ext_idle;
            ext_cnt <= 0;
        end else if (ext_cnt == EXT_HALF - 1) begin
            ext_clk <= ~ext_clk;
            ext_cnt <= 0;
        end else begin
            ext_cnt <= ext_cnt + 1;
        end
    end

    // Behavioural reference for the clock pins: latched settings plus
    // the number of enabled cycles since the direction was started.
    bit m_tx_pol, m_tx_int, m_rx_pol, m_rx_int;
    int m_tx_h = 1, m_rx_h = 1, k_tx = 0, k_rx = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_tx_pol <= 0; m_tx_int <= 0; m_tx_h <= 1; k_tx <= 0;
            m_rx_pol <= 0; m_rx_int <= 0; m_rx_h <= 1; k_rx <= 0;
        end else begin
            if (!tx_en) begin
                m_tx_pol <= tx_pol; m_tx_int <= tx_int; k_tx <= 0;
                m_tx_h   <= (tx_half == 0) ? 1 : int'(tx_half);
            end else k_tx <= k_tx + 1;
            if (!rx_en) begin
                m_rx_pol <= rx_pol; m_rx_int <= rx_int; k_rx <= 0;
                m_rx_h   <= (rx_half == 0) ? 1 : int'(rx_half);
            end else k_rx <= k_rx + 1;
        end
    end

    always @(negedge clk) begin
        if (mon_on) begin
            bit et, er;
            et = m_tx_pol ^ bit'((k_tx / m_tx_h) % 2);
            er = m_rx_pol ^ bit'((k_rx / m_rx_h) % 2);
            check(tx_clk_oe == m_tx_int, m_tx_int ? "R1" : "R3", "tx_clk_oe",
                  tx_clk_oe, m_tx_int);
            check(rx_clk_oe == m_rx_int, m_rx_int ? "R1" : "R3", "rx_clk_oe",
                  rx_clk_oe, m_rx_int);
            if (m_tx_int || k_tx == 0)
                check(tx_clk_out == et, (k_tx == 0) ? "R2" : "R1", "tx_clk_out",
                      tx_clk_out, et);
            if (m_rx_int || k_rx == 0)
                check(rx_clk_out == er, (k_rx == 0) ? "R2" : "R1", "rx_clk_out",
                      rx_clk_out, er);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog R6 actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic setup(input bit txi, input bit txp, input bit rxi, input bit rxp,
                         input bit from_tx, input int th, input int rh);
        @(negedge clk);
        tx_en = 0; rx_en = 0; ext_run = 0;
        tx_int = txi; tx_pol = txp; rx_int = rxi; rx_pol = rxp;
        tx_half = DIV_W'(th); rx_half = DIV_W'(rh);
        rx_from_tx = from_tx; ext_idle = txp;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_word(input logic [W-1:0] w, input bit txi, input bit txp,
                             input bit rxi, input bit rxp, input bit from_tx,
                             input bit ext, input int th, input int rh,
                             input bit perturb, input string tag);
        bit got;
        setup(txi, txp, rxi, rxp, from_tx, th, rh);
        tx_word = w; tx_load = 1;
        @(negedge clk);
        tx_load = 0; tx_en = 1; rx_en = 1;
        if (ext) ext_run = 1;
        got = 0;
        for (int i = 0; i < 3000 && !got; i++) begin
            @(negedge clk);
            if (perturb && i == 10) begin
                tx_pol = ~tx_pol; tx_int = ~tx_int; rx_int = ~rx_int;
                rx_pol = ~rx_pol; tx_half = 1;
            end
            if (rx_valid) got = 1;
        end
        check(got, "R6", "word valid seen", got, 1);
        if (got) begin
            check(rx_word == w, tag, "looped word", rx_word, w);
            @(negedge clk);
            check(!rx_valid, "R6", "valid one cycle", rx_valid, 0);
        end
        tx_en = 0; rx_en = 0; ext_run = 0;
        @(negedge clk);
        check(!tx_data_out, "R8", "tx data idle", tx_data_out, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(!tx_clk_oe && !rx_clk_oe, "R3", "reset oe", {tx_clk_oe, rx_clk_oe}, 0);
        check(!rx_valid, "R6", "reset valid", rx_valid, 0);
        check(!tx_data_out, "R8", "reset data", tx_data_out, 0);
        check(!tx_clk_out, "R2", "reset tx pin", tx_clk_out, 0);
        mon_on = 1;

        // Internal transmit clock fed to the receive pin, equal polarities.
        send_word(8'hA5, 1, 0, 0, 0, 1, 0, 5, 5, 0, "R4 R5 R9 pol0 tx-int rx-ext");
        send_word(8'h3C, 1, 0, 0, 0, 1, 0, 5, 5, 0, "R4 R5 R9 pol0 tx-int rx-ext");
        send_word(8'h81, 1, 1, 0, 1, 1, 0, 4, 4, 0, "R4 R5 R9 pol1 tx-int rx-ext");
        send_word(8'h7E, 1, 1, 0, 1, 1, 0, 4, 4, 0, "R4 R5 R9 pol1 tx-int rx-ext");
        // Common external clock on both pins.
        send_word(8'hC3, 0, 0, 0, 0, 0, 1, 5, 5, 0, "R3 R4 R5 R9 pol0 ext");
        send_word(8'h5A, 0, 1, 0, 1, 0, 1, 5, 5, 0, "R3 R4 R5 R9 pol1 ext");
        // Both internal, mixed pin polarities, configuration flipped mid-word.
        send_word(8'hF0, 1, 1, 1, 0, 0, 0, 5, 5, 1, "R7 R9 int");
        send_word(8'h0F, 1, 0, 1, 1, 0, 0, 3, 3, 1, "R7 R9 int");
        // Half period of zero clamps to one.
        send_word(8'h96, 1, 0, 1, 0, 0, 0, 0, 0, 0, "R1 R9 half0");

        // Partial word abandoned, next word must frame from its first bit.
        setup(1, 0, 1, 0, 0, 5, 5);
        tx_word = 8'hFF; tx_load = 1;
        @(negedge clk);
        tx_load = 0; tx_en = 1; rx_en = 1;
        repeat (35) @(negedge clk);
        tx_en = 0; rx_en = 0;
        @(negedge clk);
        check(!rx_valid, "R8", "no word after partial", rx_valid, 0);
        send_word(8'h4B, 1, 0, 1, 0, 0, 0, 5, 5, 0, "R8 realign");

        mon_on = 0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule